// File: doc/BRIEF.md
# Vectored Interrupt Request Controller

This controller collects twelve maskable interrupt sources for a small processor core. Nine of them come from on-chip logic as one-cycle set pulses. Three come from external pins, and each pin has a programmable active edge. Each source owns a request flag and an enable flag. A fixed-priority encoder chooses one winner among the requests that are enabled, but only while the global mask flag is clear. The winner is offered to the CPU as a small vector index.

Two further requests take part in arbitration. A reset request is non-maskable and always wins. A software break request has the lowest rank, needs no enable and is not held back by the mask flag.

When the CPU takes the offered vector by pulsing `irq_ack`, the pending state of the chosen source is cleared and the mask flag is set. Software can only ever clear request flags. Setting a request is left to the hardware alone.

Top module: `irqc_top`

## Requirements
- R1: After reset, all request, enable and polarity bits read 0, the mask flag reads 1, and `irq_valid` is 0.
- R2: A `src_pulse` bit sampled high at a clock edge sets that source's request bit at that edge. External pin k sets source 8 (k=0), 9 (k=1) or 7 (k=2). The request is visible three clock edges after the pin changes: two synchronizer stages, then the edge detector.
- R3: A pin raises its request on a rising edge when its polarity bit is 0, and on a falling edge when its polarity bit is 1. An edge of the opposite direction has no effect.
- R4: A write with `req_wr` clears every request bit whose `req_wdata` bit is 0 and leaves every bit written 1 unchanged. No write can set a request bit. Enable bits take `en_wdata` whole.
- R5: A maskable source competes only when its request bit is 1, its enable bit is 1 and the mask flag is 0. Among competing sources, the lowest index wins, and the presented vector is index+1.
- R6: When `irq_ack` is high while `irq_valid` is high, the presented source's pending state is cleared at that edge and the mask flag becomes 1. The acknowledge takes precedence over a same-cycle `mask_wr`.
- R7: A `brk_req` pulse leaves a break pending. The break presents vector 13 whenever nothing else wins, regardless of enables and the mask flag.
- R8: A `rst_req` pulse leaves a reset pending. It presents vector 0 ahead of every other request, and its acceptance also sets the mask flag.
- R9: A hardware set of a request bit in the same cycle as a software clear or an acknowledge clear of that bit leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pulse | input | 12 | One-cycle set pulses from on-chip sources |
| ext_pin | input | 3 | Asynchronous external interrupt pins |
| brk_req | input | 1 | Software break request pulse |
| rst_req | input | 1 | Reset request pulse |
| en_wr | input | 1 | Write strobe for the enable bits |
| en_wdata | input | 12 | New enable bits |
| req_wr | input | 1 | Write strobe for the request bits (clear only) |
| req_wdata | input | 12 | 0 clears a request bit, 1 keeps it |
| pol_wr | input | 1 | Write strobe for the pin polarity bits |
| pol_wdata | input | 3 | New polarity bits (1 = falling edge) |
| mask_wr | input | 1 | Write strobe for the global mask flag |
| mask_wdata | input | 1 | New mask flag value |
| irq_ack | input | 1 | CPU takes the presented vector |
| irq_valid | output | 1 | A vector is being presented |
| irq_vector | output | 4 | 0 reset, 1..12 source index+1, 13 break |
| req_status | output | 12 | Current request bits |
| en_status | output | 12 | Current enable bits |
| pol_status | output | 3 | Current polarity bits |
| mask_status | output | 1 | Current global mask flag |

## Verification
A hardware set can fall in the same cycle as a clear of the same request bit. The clear can come from a software write or from the acknowledge of that very source. The bench drives `src_pulse` together with a zero `req_wdata`, and separately together with `irq_ack`. It judges the outcome on `req_status` after the edge, where the bit must still be set. It also checks that the acknowledge still sets the mask flag in that cycle. The break and the maskable winner are checked against each other in the same way, first with the mask flag clear and then with it set.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int NUM_SRC = 12;
    localparam int NUM_EXT = 3;
    localparam int SYNC_STAGES = 2;
    localparam int IDX_W = $clog2(NUM_SRC);
    localparam int VEC_W = $clog2(NUM_SRC + 2);
    localparam logic [VEC_W-1:0] VEC_RST = '0;
    localparam logic [VEC_W-1:0] VEC_BRK = VEC_W'(NUM_SRC + 1);

    // Request slot fed by each external pin
    function automatic int ext_slot(input int k);
        case (k)
            0: return 8;
            1: return 9;
            default: return 7;
        endcase
    endfunction
endpackage

// File: rtl/irqc_edge_sync.sv
module irqc_edge_sync #(
    parameter int N_PINS = 3,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_i,
    input  logic [N_PINS-1:0] pol_i,
    output logic [N_PINS-1:0] edge_o
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][N_PINS-1:0] stg;
        logic [N_PINS-1:0]             prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.stg[0] = pin_i;
        for (int i = 1; i < STAGES; i++) begin
            s_d.stg[i] = s_q.stg[i-1];
        end
        s_d.prev = s_q.stg[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // Active edge: polarity-adjusted level now high, previously low
    assign edge_o = (s_q.stg[LAST] ^ pol_i) & ~(s_q.prev ^ pol_i);
endmodule

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc #(
    parameter int N   = 12,
    parameter int IDX = 4
) (
    input  logic [N-1:0]   cand_i,
    output logic           found_o,
    output logic [IDX-1:0] idx_o,
    output logic [N-1:0]   grant_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        grant_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDX'(i);
                grant_o = N'(1) << i;
            end
        end
    end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int N_EXT = NUM_EXT,
    parameter int N_SYNC = SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_pulse,
    input  logic [N_EXT-1:0] ext_pin,
    input  logic             brk_req,
    input  logic             rst_req,
    input  logic             en_wr,
    input  logic [N_SRC-1:0] en_wdata,
    input  logic             req_wr,
    input  logic [N_SRC-1:0] req_wdata,
    input  logic             pol_wr,
    input  logic [N_EXT-1:0] pol_wdata,
    input  logic             mask_wr,
    input  logic             mask_wdata,
    input  logic             irq_ack,
    output logic             irq_valid,
    output logic [VEC_W-1:0] irq_vector,
    output logic [N_SRC-1:0] req_status,
    output logic [N_SRC-1:0] en_status,
    output logic [N_EXT-1:0] pol_status,
    output logic             mask_status
);
    localparam int IW = $clog2(N_SRC);

    typedef struct packed {
        logic [N_SRC-1:0] req;
        logic [N_SRC-1:0] en;
        logic [N_EXT-1:0] pol;
        logic             mask;
        logic             brk_pend;
        logic             rst_pend;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [N_EXT-1:0] ext_edge;
    logic [N_SRC-1:0] ext_set;
    logic [N_SRC-1:0] hw_set;
    logic [N_SRC-1:0] cand;
    logic [N_SRC-1:0] grant;
    logic [IW-1:0]    win_idx;
    logic             win_found;
    logic             take;

    irqc_edge_sync #(.N_PINS(N_EXT), .STAGES(N_SYNC)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_pin),
        .pol_i  (c_q.pol),
        .edge_o (ext_edge)
    );

    always_comb begin
        ext_set = '0;
        for (int k = 0; k < N_EXT; k++) begin
            ext_set[ext_slot(k)] = ext_edge[k];
        end
    end

    assign hw_set = src_pulse | ext_set;
    assign cand   = c_q.req & c_q.en & {N_SRC{~c_q.mask}};

    irqc_prio_enc #(.N(N_SRC), .IDX(IW)) u_prio (
        .cand_i  (cand),
        .found_o (win_found),
        .idx_o   (win_idx),
        .grant_o (grant)
    );

    always_comb begin
        irq_valid  = c_q.rst_pend | win_found | c_q.brk_pend;
        if (c_q.rst_pend)   irq_vector = VEC_RST;
        else if (win_found) irq_vector = VEC_W'(win_idx) + VEC_W'(1);
        else                irq_vector = VEC_BRK;
    end

    assign take = irq_ack & irq_valid;

    always_comb begin
        logic [N_SRC-1:0] keep;
        logic             src_taken;
        logic             brk_taken;
        c_d = c_q;
        src_taken = take & ~c_q.rst_pend & win_found;
        brk_taken = take & ~c_q.rst_pend & ~win_found;
        keep = req_wr ? req_wdata : '1;
        if (src_taken) keep = keep & ~grant;
        c_d.req = (c_q.req & keep) | hw_set;
        if (en_wr)  c_d.en  = en_wdata;
        if (pol_wr) c_d.pol = pol_wdata;
        if (take)         c_d.mask = 1'b1;
        else if (mask_wr) c_d.mask = mask_wdata;
        c_d.brk_pend = brk_req | (c_q.brk_pend & ~brk_taken);
        c_d.rst_pend = rst_req | (c_q.rst_pend & ~take);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q      <= '0;
            c_q.mask <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    assign req_status  = c_q.req;
    assign en_status   = c_q.en;
    assign pol_status  = c_q.pol;
    assign mask_status = c_q.mask;

    genvar g;
    generate
        for (g = 0; g < N_SRC; g++) begin : g_bit_chk
            // R4
            sw_cannot_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !c_q.req[g] && !hw_set[g] |=> !c_q.req[g]);
            // R9
            hw_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
                hw_set[g] |=> c_q.req[g]);
        end
    endgenerate

    // R6
    accept_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> c_q.mask);

    // R5
    masked_no_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.mask && irq_valid |-> (irq_vector == VEC_RST || irq_vector == VEC_BRK));

    // R5
    single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R7
    brk_presented_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.brk_pend |-> irq_valid);

    // R8
    rst_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.rst_pend |-> irq_vector == VEC_RST);
endmodule

// File: tb/irqc_top_tb.sv
module irqc_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] src_pulse = '0;
    logic [2:0]  ext_pin = '0;
    logic        brk_req = 1'b0, rst_req = 1'b0;
    logic        en_wr = 1'b0, req_wr = 1'b0, pol_wr = 1'b0, mask_wr = 1'b0;
    logic [11:0] en_wdata = '0, req_wdata = '0;
    logic [2:0]  pol_wdata = '0;
    logic        mask_wdata = 1'b0, irq_ack = 1'b0;
    logic        irq_valid, mask_status;
    logic [3:0]  irq_vector;
    logic [11:0] req_status, en_status;
    logic [2:0]  pol_status;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    irqc_top u_dut (
        .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .ext_pin(ext_pin),
        .brk_req(brk_req), .rst_req(rst_req), .en_wr(en_wr), .en_wdata(en_wdata),
        .req_wr(req_wr), .req_wdata(req_wdata), .pol_wr(pol_wr), .pol_wdata(pol_wdata),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata), .irq_ack(irq_ack),
        .irq_valid(irq_valid), .irq_vector(irq_vector), .req_status(req_status),
        .en_status(en_status), .pol_status(pol_status), .mask_status(mask_status)
    );

    typedef struct packed {
        logic [11:0] pulse;
        logic        en_we;
        logic [11:0] en;
        logic        clr_we;
        logic [11:0] clr;
        logic        m_we;
        logic        m;
        logic        ack;
        logic        e_valid;
        logic [3:0]  e_vec;
        logic [11:0] e_req;
    } step_t;

    localparam int NSTEP = 13;
    localparam step_t STEPS [NSTEP] = '{
        '{12'h000, 1'b1, 12'hFFF, 1'b0, 12'h000, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0,  12'h000},
        '{12'h020, 1'b0, 12'h000, 1'b0, 12'h000, 1'b0, 1'b0, 1'b0, 1'b1, 4'd6,  12'h020},
        '{12'h004, 1'b0, 12'h000, 1'b0, 12'h000, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3,  12'h024},
        '{12'h000, 1'b0, 12'h000, 1'b0, 12'h000, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0,  12'h020},
        '{12'h000, 1'b0, 12'h000, 1'b0, 12'h000, 1'b1, 1'b0, 1'b0, 1'b1, 4'd6,  12'h020},
        '{12'h000, 1'b0, 12'h000, 1'b1, 12'hFDF, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0,  12'h000},
        '{12'h408, 1'b1, 12'h400, 1'b0, 12'h000, 1'b0, 1'b0, 1'b0, 1'b1, 4'd11, 12'h408},
        '{12'h000, 1'b0, 12'h000, 1'b1, 12'hFFF, 1'b0, 1'b0, 1'b0, 1'b1, 4'd11, 12'h408},
        '{12'h400, 1'b0, 12'h000, 1'b1, 12'h000, 1'b0, 1'b0, 1'b0, 1'b1, 4'd11, 12'h400},
        '{12'h400, 1'b0, 12'h000, 1'b0, 12'h000, 1'b1, 1'b0, 1'b1, 1'b0, 4'd0,  12'h400},
        '{12'h000, 1'b1, 12'h000, 1'b0, 12'h000, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0,  12'h400},
        '{12'h000, 1'b1, 12'hFFF, 1'b0, 12'h000, 1'b0, 1'b0, 1'b0, 1'b1, 4'd11, 12'h400},
        '{12'h000, 1'b0, 12'h000, 1'b1, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0,  12'h000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        src_pulse = '0; en_wr = 0; req_wr = 0; pol_wr = 0; mask_wr = 0;
        irq_ack = 0; brk_req = 0; rst_req = 0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 req", 32'(req_status), 32'h0);
        chk("R1 en", 32'(en_status), 32'h0);
        chk("R1 pol", 32'(pol_status), 32'h0);
        chk("R1 mask", 32'(mask_status), 32'h1);
        chk("R1 valid", 32'(irq_valid), 32'h0);

        // Table: R2 R4 R5 R6 R9
        for (int s = 0; s < NSTEP; s++) begin
            src_pulse = STEPS[s].pulse;
            en_wr = STEPS[s].en_we;   en_wdata = STEPS[s].en;
            req_wr = STEPS[s].clr_we; req_wdata = STEPS[s].clr;
            mask_wr = STEPS[s].m_we;  mask_wdata = STEPS[s].m;
            irq_ack = STEPS[s].ack;
            tick();
            idle();
            chk($sformatf("R5 step%0d valid", s), 32'(irq_valid), 32'(STEPS[s].e_valid));
            if (STEPS[s].e_valid)
                chk($sformatf("R5 step%0d vector", s), 32'(irq_vector), 32'(STEPS[s].e_vec));
            chk($sformatf("R4/R9 step%0d req", s), 32'(req_status), 32'(STEPS[s].e_req));
        end

        // R7 break with nothing else pending, mask clear
        brk_req = 1; tick(); idle();
        chk("R7 brk alone", 32'(irq_vector), 32'd13);
        src_pulse = 12'h001; tick(); idle();
        chk("R7 brk below source", 32'(irq_vector), 32'd1);
        irq_ack = 1; tick(); idle();
        chk("R6 mask after ack", 32'(mask_status), 32'h1);
        chk("R7 brk under mask", 32'(irq_vector), 32'd13);
        chk("R6 req cleared", 32'(req_status), 32'h0);
        irq_ack = 1; tick(); idle();
        chk("R7 brk taken", 32'(irq_valid), 32'h0);

        // R8 reset request beats a source; ack beats mask write
        src_pulse = 12'h008; rst_req = 1; mask_wr = 1; mask_wdata = 0; tick(); idle();
        chk("R8 reset first", 32'(irq_vector), 32'd0);
        irq_ack = 1; mask_wr = 1; mask_wdata = 0; tick(); idle();
        chk("R8 ack masks", 32'(mask_status), 32'h1);
        chk("R8 masked after", 32'(irq_valid), 32'h0);
        mask_wr = 1; mask_wdata = 0; tick(); idle();
        chk("R5 source after reset", 32'(irq_vector), 32'd4);
        req_wr = 1; req_wdata = 12'h000; tick(); idle();

        // R2 external pin 0, rising, three-edge latency
        ext_pin[0] = 1; tick(); tick();
        chk("R2 not yet", 32'(req_status), 32'h000);
        tick();
        chk("R2 pin0 slot8", 32'(req_status), 32'h100);
        req_wr = 1; req_wdata = 12'h000; tick(); idle();
        // R3 falling edge ignored under polarity 0
        ext_pin[0] = 0; repeat (4) tick();
        chk("R3 fall ignored", 32'(req_status), 32'h000);
        // R3 polarity 1 on pin 1
        pol_wr = 1; pol_wdata = 3'b010; tick(); idle();
        chk("R3 pol written", 32'(pol_status), 32'h2);
        ext_pin[1] = 1; repeat (4) tick();
        chk("R3 rise ignored pol1", 32'(req_status), 32'h000);
        ext_pin[1] = 0; ext_pin[2] = 1; repeat (3) tick();
        chk("R3 fall pin1 and rise pin2", 32'(req_status), 32'h280);

        finish_run();
    end
endmodule